// File: doc/BRIEF.md
# Table-Driven March Self-Test Sequencer

This block is a self-test engine for a single-port, word-wide RAM. It steps through a short list of march elements. Each element names an address direction and a list of one to four symbolic operations. At every address the block runs the whole list of the current element, then moves to the next address. When the last address is done it moves to the next element. Symbolic 0 and 1 are mapped onto a data background word and its bitwise complement, so a plain bit algorithm also exercises multi-bit words. Every read is compared over the full word. The first miscompare is recorded for diagnosis. The run then goes on to the end of the list.

The element list comes either from a fixed three-element algorithm built into the block or from a flat table input. An element can request an idle pause before its first access, which exposes cells that lose their data over time. The memory port assumes a synchronous RAM: read data appears on the cycle after the read request.

Top module: `march_bist`

## Requirements
- R1: An element with direction code 00 visits addresses 0 up to WORDS-1. Code 01 visits WORDS-1 down to 0. Codes 10 and 11 ("either order") visit in ascending order. All operations of an element are issued at one address before the address changes.
- R2: Each operation is a 2-bit code: bit 1 set means write and bit 1 clear means read; bit 0 clear selects the background and bit 0 set selects its complement. A write drives that word on `mem_wdata`.
- R3: A read compares the whole `mem_rdata` word, taken one cycle after the read request, with the background (r0) or its complement (r1). Any difference raises `fail`.
- R4: The first miscompare of a run latches the address, the element index, the operation index within the element (0..3) and the data read. Later miscompares in the same run leave these values unchanged.
- R5: With `use_builtin` high, the block runs three elements: w0 in either order; ascending r0,w1; descending r1,w0,r0. On WORDS words this is exactly 6·WORDS memory accesses.
- R6: Element k of `prog_table` occupies bits [14k+13:14k]. Its fields are: direction in [1:0], operation count in [4:2], pause flag in [5], and operation j in [7+2j:6+2j]. The table holds up to MAX_ELEM elements. The first element with count 0 ends the run, and later entries are not executed.
- R7: When an element's pause flag is set and `pause_len` is non-zero, no memory access takes place for at least `pause_len` cycles before that element's first access. When `pause_len` is zero the element starts after one idle cycle.
- R8: A `start` pulse while `busy` is high is ignored. The running test neither restarts nor changes its access count.
- R9: `done` rises at the end of a run and stays high until the next accepted `start`. An accepted `start` clears `done` and `fail` at the next clock edge.
- R10: After reset, `busy`, `done`, `fail` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Begin a run when idle |
| use_builtin | input | 1 | Select built-in algorithm instead of `prog_table` |
| prog_table | input | MAX_ELEM*14 | Programmed element list |
| background | input | DATA_W | Data background word for symbolic 0 |
| pause_len | input | PAUSE_W | Idle cycles before a pause-flagged element |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | $clog2(WORDS) | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run complete, held until next start |
| fail | output | 1 | At least one miscompare in this run |
| fail_addr | output | $clog2(WORDS) | Address of first miscompare |
| fail_elem | output | $clog2(MAX_ELEM) | Element index of first miscompare |
| fail_op | output | 2 | Operation index of first miscompare |
| fail_data | output | DATA_W | Data read at first miscompare |

## Verification
The bench builds the block with WORDS=12, DATA_W=4, MAX_ELEM=8 and PAUSE_W=8. A 12-word memory is not a power of two, so both direction end points are tested off the natural wrap of the address counter. The 4-bit word lets the 0101 background and its 1010 complement be checked directly. The bench memory model can inject stuck bits, an aliased address decoder and a cell that decays after a long idle stretch. The built-in algorithm is shown to catch the first two, and only a paused element catches the third. The 8-bit pause counter reaches a 40-cycle wait that outlasts the 30-cycle decay threshold.

// File: rtl/march_bist_pkg.sv
`timescale 1ns/1ps
package march_bist_pkg;

   localparam int OPS_PER_ELEM = 4;
   localparam int OP_W         = 2;
   localparam int CNT_W        = 3;
   localparam int ELEM_W       = 2 + CNT_W + 1 + OPS_PER_ELEM*OP_W;

   localparam logic [1:0] DIR_UP   = 2'b00;
   localparam logic [1:0] DIR_DOWN = 2'b01;

   // operation codes: bit1 = write, bit0 = complement of background
   localparam logic [1:0] OP_R0 = 2'b00;
   localparam logic [1:0] OP_R1 = 2'b01;
   localparam logic [1:0] OP_W0 = 2'b10;
   localparam logic [1:0] OP_W1 = 2'b11;

   typedef struct packed {
      logic [OPS_PER_ELEM*OP_W-1:0] ops;
      logic                         pause;
      logic [CNT_W-1:0]             cnt;
      logic [1:0]                   dir;
   } elem_t;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_LOAD   = 3'd1,
      S_WAIT   = 3'd2,
      S_ACCESS = 3'd3,
      S_CHECK  = 3'd4
   } state_e;

   // fixed three-element algorithm, 6n accesses
   function automatic elem_t builtin_elem(input int idx);
      elem_t e;
      e = '0;
      case (idx)
         0: begin
            e.dir = 2'b10;
            e.cnt = 3'd1;
            e.ops = {6'b0, OP_W0};
         end
         1: begin
            e.dir = DIR_UP;
            e.cnt = 3'd2;
            e.ops = {4'b0, OP_W1, OP_R0};
         end
         2: begin
            e.dir = DIR_DOWN;
            e.cnt = 3'd3;
            e.ops = {2'b0, OP_R0, OP_W0, OP_R1};
         end
         default: e = '0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/march_addr.sv
`timescale 1ns/1ps
module march_addr #(
   parameter int WORDS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     down,
   input  logic                     step,
   output logic [$clog2(WORDS)-1:0] addr,
   output logic                     at_end
);

   localparam int ADDR_W = $clog2(WORDS);
   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(WORDS - 1);

   logic down_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= '0;
         down_r <= 1'b0;
      end else if (load) begin
         down_r <= down;
         addr   <= down ? TOP : '0;
      end else if (step) begin
         addr <= down_r ? addr - 1'b1 : addr + 1'b1;
      end
   end

   assign at_end = down_r ? (addr == '0) : (addr == TOP);

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ((addr == $past(addr) + 1'b1) || (addr == $past(addr) - 1'b1))) // R1
      else $error("address moved by more than one word");

endmodule

// File: rtl/march_cmp.sv
`timescale 1ns/1ps
module march_cmp #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int EL_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              chk,
   input  logic [DATA_W-1:0] exp_word,
   input  logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] addr,
   input  logic [EL_W-1:0]   elem,
   input  logic [1:0]        op,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [EL_W-1:0]   fail_elem,
   output logic [1:0]        fail_op,
   output logic [DATA_W-1:0] fail_data
);

   logic miss;
   assign miss = chk && (rdata != exp_word);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
         fail_op   <= '0;
         fail_data <= '0;
      end else if (miss && !fail) begin
         fail      <= 1'b1;
         fail_addr <= addr;
         fail_elem <= elem;
         fail_op   <= op;
         fail_data <= rdata;
      end
   end

   AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clr) |=> (fail && $stable(fail_addr) && $stable(fail_data) && $stable(fail_op))) // R4
      else $error("first miscompare record overwritten");

endmodule

// File: rtl/march_seq.sv
`timescale 1ns/1ps
module march_seq
   import march_bist_pkg::*;
#(
   parameter int MAX_ELEM = 8,
   parameter int PAUSE_W  = 16,
   parameter bit PAUSE_EN = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [CNT_W-1:0]                cnt,
   input  logic                            pause_req,
   input  logic                            is_write,
   input  logic                            at_end,
   input  logic [PAUSE_W-1:0]              pause_len,
   output state_e                          st,
   output logic [$clog2(MAX_ELEM+1)-1:0]   elem_idx,
   output logic [1:0]                      op_idx,
   output logic                            done,
   output logic                            clr,
   output logic                            addr_load,
   output logic                            addr_step,
   output logic                            chk
);

   localparam int IDX_W = $clog2(MAX_ELEM + 1);

   logic [CNT_W-1:0]   cnt_eff;
   logic [1:0]         last_idx;
   logic               list_end;
   logic               last_op;
   logic               adv;
   logic               pause_go;
   logic [PAUSE_W-1:0] wait_cnt;

   always_comb begin
      cnt_eff  = (cnt > CNT_W'(OPS_PER_ELEM)) ? CNT_W'(OPS_PER_ELEM) : cnt;
      last_idx = 2'(cnt_eff - 1'b1);
      list_end = (elem_idx == IDX_W'(MAX_ELEM)) || (cnt == '0);
      last_op  = (op_idx == last_idx);
      adv      = ((st == S_ACCESS) && is_write) || (st == S_CHECK);
   end

   if (PAUSE_EN) begin : g_pause
      assign pause_go = pause_req && (pause_len != '0);
   end else begin : g_no_pause
      assign pause_go = 1'b0;
   end

   assign clr       = (st == S_IDLE) && start;
   assign addr_load = (st == S_LOAD);
   assign addr_step = adv && last_op && !at_end;
   assign chk       = (st == S_CHECK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         elem_idx <= '0;
         op_idx   <= '0;
         done     <= 1'b0;
         wait_cnt <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  st       <= S_LOAD;
                  elem_idx <= '0;
                  op_idx   <= '0;
                  done     <= 1'b0;
               end
            end
            S_LOAD: begin
               op_idx <= '0;
               if (list_end) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
               end else if (pause_go) begin
                  st       <= S_WAIT;
                  wait_cnt <= pause_len;
               end else begin
                  st <= S_ACCESS;
               end
            end
            S_WAIT: begin
               if (wait_cnt <= PAUSE_W'(1)) st <= S_ACCESS;
               else wait_cnt <= wait_cnt - 1'b1;
            end
            S_ACCESS: begin
               if (!is_write) st <= S_CHECK;
            end
            default: ;
         endcase

         if (adv) begin
            if (!last_op) begin
               op_idx <= op_idx + 1'b1;
               st     <= S_ACCESS;
            end else if (at_end) begin
               elem_idx <= elem_idx + 1'b1;
               st       <= S_LOAD;
            end else begin
               op_idx <= '0;
               st     <= S_ACCESS;
            end
         end
      end
   end

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done) // R9
      else $error("done dropped without a start");

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != S_IDLE) && start) |=> !((st == S_LOAD) && (elem_idx == '0))) // R8
      else $error("start restarted a running test");

endmodule

// File: rtl/march_bist.sv
`timescale 1ns/1ps
module march_bist
   import march_bist_pkg::*;
#(
   parameter int WORDS    = 16,
   parameter int DATA_W   = 8,
   parameter int MAX_ELEM = 8,
   parameter int PAUSE_W  = 16,
   parameter bit PAUSE_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         use_builtin,
   input  logic [MAX_ELEM*ELEM_W-1:0]   prog_table,
   input  logic [DATA_W-1:0]            background,
   input  logic [PAUSE_W-1:0]           pause_len,
   output logic                         mem_en,
   output logic                         mem_we,
   output logic [$clog2(WORDS)-1:0]     mem_addr,
   output logic [DATA_W-1:0]            mem_wdata,
   input  logic [DATA_W-1:0]            mem_rdata,
   output logic                         busy,
   output logic                         done,
   output logic                         fail,
   output logic [$clog2(WORDS)-1:0]     fail_addr,
   output logic [$clog2(MAX_ELEM)-1:0]  fail_elem,
   output logic [1:0]                   fail_op,
   output logic [DATA_W-1:0]            fail_data
);

   localparam int ADDR_W = $clog2(WORDS);
   localparam int EL_W   = $clog2(MAX_ELEM);
   localparam int IDX_W  = $clog2(MAX_ELEM + 1);
   localparam int TBL_N  = 2**EL_W;

   initial begin
      assert (WORDS >= 2) else $error("WORDS must be at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (MAX_ELEM >= 2 && MAX_ELEM <= 8) else $error("MAX_ELEM must lie in 2..8");
      assert (PAUSE_W >= 1) else $error("PAUSE_W must be at least 1");
   end

   elem_t              tbl [TBL_N];
   elem_t              cur;
   logic [1:0]         cur_op;
   logic [DATA_W-1:0]  patt;
   state_e             st;
   logic [IDX_W-1:0]   elem_idx;
   logic [1:0]         op_idx;
   logic               clr;
   logic               addr_load;
   logic               addr_step;
   logic               chk;
   logic [ADDR_W-1:0]  addr;
   logic               at_end;

   for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
      if (g < MAX_ELEM) begin : g_live
         assign tbl[g] = use_builtin ? builtin_elem(g)
                                     : elem_t'(prog_table[g*ELEM_W +: ELEM_W]);
      end else begin : g_pad
         assign tbl[g] = '0;
      end
   end

   assign cur    = (elem_idx < IDX_W'(MAX_ELEM)) ? tbl[elem_idx[EL_W-1:0]] : '0;
   assign cur_op = cur.ops[{op_idx, 1'b0} +: OP_W];
   assign patt   = cur_op[0] ? ~background : background;

   march_seq #(
      .MAX_ELEM (MAX_ELEM),
      .PAUSE_W  (PAUSE_W),
      .PAUSE_EN (PAUSE_EN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cnt       (cur.cnt),
      .pause_req (cur.pause),
      .is_write  (cur_op[1]),
      .at_end    (at_end),
      .pause_len (pause_len),
      .st        (st),
      .elem_idx  (elem_idx),
      .op_idx    (op_idx),
      .done      (done),
      .clr       (clr),
      .addr_load (addr_load),
      .addr_step (addr_step),
      .chk       (chk)
   );

   march_addr #(
      .WORDS (WORDS)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (addr_load),
      .down   (cur.dir == DIR_DOWN),
      .step   (addr_step),
      .addr   (addr),
      .at_end (at_end)
   );

   march_cmp #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .EL_W   (EL_W)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .chk       (chk),
      .exp_word  (patt),
      .rdata     (mem_rdata),
      .addr      (addr),
      .elem      (elem_idx[EL_W-1:0]),
      .op        (op_idx),
      .fail      (fail),
      .fail_addr (fail_addr),
      .fail_elem (fail_elem),
      .fail_op   (fail_op),
      .fail_data (fail_data)
   );

   assign mem_en    = (st == S_ACCESS);
   assign mem_we    = cur_op[1];
   assign mem_addr  = addr;
   assign mem_wdata = patt;
   assign busy      = (st != S_IDLE);

   AST_WRITE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> ((mem_wdata == background) || (mem_wdata == ~background))) // R2
      else $error("write data is neither background nor complement");

   AST_READ_THEN_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> (chk && !mem_en)) // R3
      else $error("read not followed by a compare cycle");

endmodule

// File: tb/tb_march_bist.sv
`timescale 1ns/1ps
module tb_march_bist;

   localparam int WORDS    = 12;
   localparam int DATA_W   = 4;
   localparam int MAX_ELEM = 8;
   localparam int PAUSE_W  = 8;
   localparam int EW       = 14;
   localparam int DECAY    = 30;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start = 1'b0;
   logic                   use_builtin = 1'b1;
   logic [MAX_ELEM*EW-1:0] prog_table = '0;
   logic [DATA_W-1:0]      background = 4'b0101;
   logic [PAUSE_W-1:0]     pause_len = '0;
   logic                   mem_en, mem_we;
   logic [3:0]             mem_addr;
   logic [DATA_W-1:0]      mem_wdata;
   logic [DATA_W-1:0]      mem_rdata = '0;
   logic                   busy, done, fail;
   logic [3:0]             fail_addr;
   logic [2:0]             fail_elem;
   logic [1:0]             fail_op;
   logic [DATA_W-1:0]      fail_data;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int nacc = 0;
   int idle = 0;

   logic [DATA_W-1:0] ram     [WORDS];
   logic [DATA_W-1:0] sa_mask [WORDS];
   logic [DATA_W-1:0] sa_val  [WORDS];
   logic              alias_on = 1'b0;
   logic [3:0]        alias_src = '0, alias_dst = '0;
   logic              ret_on = 1'b0;
   logic [3:0]        ret_addr = '0;

   logic [3:0]        lg_addr [256];
   logic              lg_we   [256];
   logic [DATA_W-1:0] lg_data [256];
   int                lg_cyc  [256];

   always #5 clk = ~clk;

   march_bist #(
      .WORDS    (WORDS),
      .DATA_W   (DATA_W),
      .MAX_ELEM (MAX_ELEM),
      .PAUSE_W  (PAUSE_W),
      .PAUSE_EN (1'b1)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .use_builtin (use_builtin),
      .prog_table  (prog_table),
      .background  (background),
      .pause_len   (pause_len),
      .mem_en      (mem_en),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .busy        (busy),
      .done        (done),
      .fail        (fail),
      .fail_addr   (fail_addr),
      .fail_elem   (fail_elem),
      .fail_op     (fail_op),
      .fail_data   (fail_data)
   );

   // memory model with injectable faults
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_en) idle <= 0;
      else idle <= idle + 1;
      if (mem_en && mem_we) begin
         ram[mem_addr] <= mem_wdata;
         if (alias_on && mem_addr == alias_src) ram[alias_dst] <= mem_wdata;
      end
      if (mem_en && !mem_we)
         mem_rdata <= (ram[mem_addr] & ~sa_mask[mem_addr]) | (sa_val[mem_addr] & sa_mask[mem_addr]);
      if (!mem_en && ret_on && idle >= DECAY) ram[ret_addr] <= '0;
   end

   always @(negedge clk) begin
      if (rst_n && mem_en && nacc < 256) begin
         lg_addr[nacc] = mem_addr;
         lg_we[nacc]   = mem_we;
         lg_data[nacc] = mem_wdata;
         lg_cyc[nacc]  = cyc;
         nacc = nacc + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp_v);
      nchk++;
      if (act !== exp_v) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   function automatic logic [EW-1:0] mk(input logic [1:0] dir, input logic [2:0] n,
                                        input logic p, input logic [7:0] ops);
      return {ops, p, n, dir};
   endfunction

   task automatic set_elem(input int i, input logic [EW-1:0] e);
      prog_table[i*EW +: EW] = e;
   endtask

   task automatic clear_faults();
      for (int i = 0; i < WORDS; i++) begin
         sa_mask[i] = '0;
         sa_val[i]  = '0;
      end
      alias_on = 1'b0;
      ret_on   = 1'b0;
      prog_table = '0;
   endtask

   task automatic run_test();
      @(negedge clk);
      nacc  = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
      chk("R9 done after run", done, 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 busy after reset", busy, 0);
      chk("R10 done after reset", done, 0);
      chk("R10 fail after reset", fail, 0);
      chk("R10 mem_en after reset", mem_en, 0);
   endtask

   task automatic t_builtin_clean();
      int ok;
      clear_faults();
      use_builtin = 1'b1;
      background  = 4'b0101;
      run_test();
      chk("R5 access count 6n", nacc, 6*WORDS);
      chk("R3 no miscompare on clean memory", fail, 0);
      ok = 1;
      for (int i = 0; i < WORDS; i++)
         if (lg_we[i] !== 1'b1 || lg_addr[i] !== 4'(i) || lg_data[i] !== 4'b0101) ok = 0;
      chk("R1 either-order element ascends writing background", ok, 1);
      chk("R1 elem1 first read addr", lg_addr[12], 0);
      chk("R2 elem1 op1 writes complement", {lg_we[13], lg_data[13]}, {1'b1, 4'b1010});
      chk("R1 elem1 ops at same address", lg_addr[13], 0);
      chk("R1 descending element starts at top", lg_addr[36], WORDS-1);
      chk("R2 elem2 op1 writes background", {lg_we[37], lg_data[37]}, {1'b1, 4'b0101});
      chk("R1 descending element ends at 0", lg_addr[71], 0);
   endtask

   task automatic t_start_ignored();
      clear_faults();
      use_builtin = 1'b1;
      @(negedge clk);
      nacc  = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
      chk("R8 done reached", done, 1);
      chk("R8 access count unchanged by extra start", nacc, 6*WORDS);
   endtask

   task automatic t_stuck_bits();
      clear_faults();
      use_builtin = 1'b1;
      background  = 4'b0101;
      sa_mask[5] = 4'b0001; sa_val[5] = 4'b0001;
      sa_mask[3] = 4'b0001; sa_val[3] = 4'b0001;
      run_test();
      chk("R3 stuck bit flagged", fail, 1);
      chk("R4 first failing addr", fail_addr, 5);
      chk("R4 failing element", fail_elem, 2);
      chk("R4 failing op", fail_op, 0);
      chk("R4 failing data", fail_data, 4'b1011);
   endtask

   task automatic t_done_hold();
      repeat (10) @(negedge clk);
      chk("R9 done held", done, 1);
      chk("R9 fail held", fail, 1);
      clear_faults();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 done cleared by start", done, 0);
      chk("R9 fail cleared by start", fail, 0);
      chk("R9 busy after start", busy, 1);
      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
   endtask

   task automatic t_alias();
      clear_faults();
      use_builtin = 1'b1;
      background  = 4'b0101;
      alias_on  = 1'b1;
      alias_src = 4'd2;
      alias_dst = 4'd9;
      run_test();
      chk("R3 alias flagged", fail, 1);
      chk("R4 alias addr", fail_addr, 9);
      chk("R4 alias element", fail_elem, 1);
      chk("R4 alias data", fail_data, 4'b1010);
   endtask

   task automatic t_prog_clean();
      clear_faults();
      use_builtin = 1'b0;
      background  = 4'b0011;
      set_elem(0, mk(2'b01, 3'd1, 1'b0, 8'h03));
      set_elem(1, mk(2'b11, 3'd2, 1'b0, 8'h05));
      set_elem(2, mk(2'b00, 3'd0, 1'b0, 8'h00));
      set_elem(3, mk(2'b00, 3'd1, 1'b0, 8'h02));
      run_test();
      chk("R6 terminator stops list", nacc, 3*WORDS);
      chk("R1 down element starts at top", lg_addr[0], WORDS-1);
      chk("R2 w1 writes complement", lg_data[0], 4'b1100);
      chk("R1 code 11 runs ascending", lg_addr[12], 0);
      chk("R1 code 11 ends at top", lg_addr[35], WORDS-1);
      chk("R3 programmed run clean", fail, 0);
   endtask

   task automatic t_prog_four_ops();
      clear_faults();
      use_builtin = 1'b0;
      background  = 4'b0101;
      set_elem(0, mk(2'b00, 3'd1, 1'b0, 8'h02));
      set_elem(1, mk(2'b00, 3'd4, 1'b0, 8'h70));
      sa_mask[7] = 4'b1000; sa_val[7] = 4'b0000;
      run_test();
      chk("R3 four-op element flags", fail, 1);
      chk("R4 op index 3", fail_op, 3);
      chk("R4 four-op addr", fail_addr, 7);
      chk("R4 four-op element", fail_elem, 1);
      chk("R4 four-op data", fail_data, 4'b0010);
   endtask

   task automatic t_pause(input int len, input int expect_fail);
      clear_faults();
      use_builtin = 1'b0;
      background  = 4'b0101;
      pause_len   = 8'(len);
      set_elem(0, mk(2'b00, 3'd1, 1'b0, 8'h02));
      set_elem(1, mk(2'b00, 3'd1, 1'b1, 8'h00));
      ret_on   = 1'b1;
      ret_addr = 4'd4;
      run_test();
      chk("R7 retention result", fail, expect_fail);
      if (len != 0) begin
         chk("R7 idle gap covers pause", (lg_cyc[12] - lg_cyc[11] - 1) >= len, 1);
         chk("R7 decayed cell addr", fail_addr, 4);
         chk("R7 decayed data", fail_data, 0);
      end else begin
         chk("R7 zero pause gap", lg_cyc[12] - lg_cyc[11], 2);
      end
   endtask

   initial begin
      #1_500_000;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < WORDS; i++) ram[i] = '0;
      clear_faults();
      t_reset();
      t_builtin_clean();
      t_start_ignored();
      t_stuck_bits();
      t_done_hold();
      t_alias();
      t_prog_clean();
      t_prog_four_ops();
      t_pause(40, 1);
      t_pause(0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule